// File: doc/BRIEF.md
# Interrupt Destination Resolver with Rotation

This block takes one interrupt delivery request per accepted cycle (a destination byte, a destination-mode bit and a 3-bit delivery mode) and turns it into a target mask over N local interrupt controllers, with N at most 8. Each controller supplies its own 8-bit logical identifier on a packed input vector. In physical mode the destination byte is a controller index or the broadcast value 0xFF. In logical mode every controller whose identifier shares at least one set bit with the destination byte becomes a target.

Lowest-priority delivery does not compare any priority. An 8-bit rotation counter is kept instead. Its value modulo the number of matched controllers chooses one of them, so repeated requests walk through the matched set. The result is registered, and the mask and an error flag appear one cycle after the request is accepted.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, out_valid, out_mask and out_err are all 0 and the rotation counter is 0, so the first lowest-priority request picks the lowest-indexed matched controller.
- R2: With req_logical=0 and req_dest=0xFF, every bit of out_mask is set (broadcast).
- R3: With req_logical=0 and req_dest below N, only bit req_dest of out_mask is set. A req_dest of N or above (other than 0xFF) gives an empty mask with out_err=0.
- R4: With req_logical=1, bit i of out_mask is set exactly when the bitwise AND of req_dest and lcl_logid[8*i+7:8*i] is nonzero.
- R5: With req_logical=1 and req_mode=3'b001 (lowest priority), out_mask holds only the k-th matched controller in ascending index order, where k is the rotation counter modulo the match count. With no match the mask is empty.
- R6: The rotation counter is 8 bits wide. It advances by one after each logical lowest-priority request that had at least one match, keeps its value otherwise, and wraps from 255 to 0.
- R7: req_mode=3'b001 with req_logical=0 gives out_err=1 and an empty out_mask, and the rotation counter does not change.
- R8: Every req_mode other than 3'b001 passes the full matched set through with out_err=0.
- R9: req_ready is always 1. out_valid is high exactly in the cycle after a cycle with req_valid high. out_mask and out_err keep their values while no request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Request can be accepted (always 1) |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 1 = logical destination mode, 0 = physical |
| req_mode | input | 3 | Delivery mode; 3'b001 = lowest priority |
| lcl_logid | input | 8*N | Logical identifier of each controller, controller i at bits 8*i+7:8*i |
| out_valid | output | 1 | Result present |
| out_mask | output | N | Target controllers |
| out_err | output | 1 | Lowest priority was requested in physical mode |

## Verification
The rotation counter is the only hidden state that lasts beyond one request. If it were wrong, the first lowest-priority request after the fault would already name a different controller. The same would happen after a physical-mode fault or an unmatched request that wrongly advanced it. A counter that fails to wrap at 8 bits shows up after 256 deliveries over a match count that does not divide 256. The bench therefore runs a three-member set past the wrap and checks the pick on the following request.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  typedef enum logic [2:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMI    = 3'd2,
    DM_RSVD3  = 3'd3,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_RSVD6  = 3'd6,
    DM_EXTINT = 3'd7
  } dlv_mode_e;

  localparam int unsigned ID_W = 8;
  localparam logic [ID_W-1:0] BCAST_ID = 8'hFF;

endpackage

// File: rtl/dest_match.sv
module dest_match
  import irq_route_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic [ID_W-1:0]   dest,
  input  logic              logical,
  input  logic [N*ID_W-1:0] logids,
  output logic [N-1:0]      match
);

  logic [N-1:0] phys_hit;
  logic [N-1:0] log_hit;

  for (genvar i = 0; i < N; i++) begin : g_ctl
    assign phys_hit[i] = (dest == BCAST_ID) || (dest == ID_W'(i));
    assign log_hit[i]  = |(logids[i*ID_W +: ID_W] & dest);
  end

  assign match = logical ? log_hit : phys_hit;

endmodule

// File: rtl/rot_pick.sv
module rot_pick #(
  parameter int unsigned N     = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic [N-1:0]     cand,
  input  logic [CNT_W-1:0] rot,
  output logic [N-1:0]     pick,
  output logic             any
);

  logic [CNT_W-1:0] hits;
  logic [CNT_W-1:0] slot;
  logic [CNT_W-1:0] seen;

  always_comb begin
    hits = '0;
    for (int i = 0; i < N; i++) begin
      hits = hits + CNT_W'(cand[i]);
    end
  end

  assign any  = (hits != '0);
  assign slot = any ? (rot % hits) : '0;

  always_comb begin
    pick = '0;
    seen = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i]) begin
        if (seen == slot) pick[i] = 1'b1;
        seen = seen + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rot_counter.sv
module rot_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] value
);

  logic [CNT_W-1:0] value_d;

  always_comb begin
    value_d = value;
    if (bump) value_d = value + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= value_d;
  end

  // R6
  rot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bump |=> value == CNT_W'($past(value) + 1'b1));

  // R6
  rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(value));

endmodule

// File: rtl/irq_dest_resolver.sv
module irq_dest_resolver
  import irq_route_pkg::*;
#(
  parameter int unsigned N     = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [7:0]        req_dest,
  input  logic              req_logical,
  input  logic [2:0]        req_mode,
  input  logic [N*8-1:0]    lcl_logid,
  output logic              out_valid,
  output logic [N-1:0]      out_mask,
  output logic              out_err
);

  logic [N-1:0]     match;
  logic [N-1:0]     pick;
  logic             any_hit;
  logic [CNT_W-1:0] rot;
  logic             is_lowpri;
  logic             fault;
  logic             use_pick;
  logic             bump;
  logic [N-1:0]     mask_d;
  logic             err_d;
  logic             valid_d;

  assign req_ready = 1'b1;

  dest_match #(.N(N)) i_match (
    .dest    (req_dest),
    .logical (req_logical),
    .logids  (lcl_logid),
    .match   (match)
  );

  rot_pick #(.N(N), .CNT_W(CNT_W)) i_pick (
    .cand (match),
    .rot  (rot),
    .pick (pick),
    .any  (any_hit)
  );

  rot_counter #(.CNT_W(CNT_W)) i_rot (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (bump),
    .value (rot)
  );

  assign is_lowpri = (req_mode == DM_LOWPRI);
  assign fault     = is_lowpri && !req_logical;
  assign use_pick  = is_lowpri && req_logical;
  assign bump      = req_valid && use_pick && any_hit;

  always_comb begin
    valid_d = req_valid;
    mask_d  = out_mask;
    err_d   = out_err;
    if (req_valid) begin
      err_d = fault;
      if (fault)         mask_d = '0;
      else if (use_pick) mask_d = pick;
      else               mask_d = match;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_mask  <= mask_d;
      out_err   <= err_d;
    end
  end

  // R7
  err_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_mask == '0);

  // R5
  pick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && use_pick && (match != '0)) |=> $countones(out_mask) == 1);

  // R5
  pick_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick & ~match) == '0);

  // R2
  bcast_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_logical && !is_lowpri && req_dest == BCAST_ID)
      |=> &out_mask);

  // R3
  phys_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_logical && !is_lowpri && req_dest != BCAST_ID
      && 32'(req_dest) >= N) |=> (out_mask == '0 && !out_err));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R9
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && $stable(out_mask) && $stable(out_err)));

endmodule

// File: tb/test_irq_dest_resolver.sv
module test_irq_dest_resolver;

  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam logic [63:0] IDS = 64'h8844221108040201;

  // {dest[20:13], logical[12], mode[11:9], exp_mask[8:1], exp_err[0]}
  localparam logic [20:0] VEC [16] = '{
    {8'hFF, 1'b0, 3'd0, 8'hFF, 1'b0},  // R2 broadcast
    {8'h03, 1'b0, 3'd0, 8'h08, 1'b0},  // R3 single id
    {8'h07, 1'b0, 3'd4, 8'h80, 1'b0},  // R3 R8 top id, other mode
    {8'h08, 1'b0, 3'd0, 8'h00, 1'b0},  // R3 id out of range
    {8'h05, 1'b1, 3'd0, 8'h55, 1'b0},  // R4 logical match
    {8'h30, 1'b1, 3'd5, 8'h30, 1'b0},  // R4 R8
    {8'h00, 1'b1, 3'd0, 8'h00, 1'b0},  // R4 nothing matches
    {8'h03, 1'b1, 3'd1, 8'h01, 1'b0},  // R5 rot 0 of 4
    {8'h03, 1'b1, 3'd1, 8'h02, 1'b0},  // R5 rot 1 of 4
    {8'h40, 1'b1, 3'd1, 8'h40, 1'b0},  // R5 single match
    {8'h00, 1'b1, 3'd1, 8'h00, 1'b0},  // R5 R6 no match, no advance
    {8'h03, 1'b1, 3'd1, 8'h20, 1'b0},  // R6 rot 3 of 4
    {8'h03, 1'b0, 3'd1, 8'h00, 1'b1},  // R7 physical lowest priority
    {8'h03, 1'b1, 3'd1, 8'h01, 1'b0},  // R7 R6 counter was held, 4 mod 4
    {8'h0F, 1'b1, 3'd7, 8'hFF, 1'b0},  // R8 full set passed
    {8'h0F, 1'b1, 3'd1, 8'h20, 1'b0}   // R5 5 mod 8
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [7:0]    req_dest;
  logic          req_logical;
  logic [2:0]    req_mode;
  logic [N*8-1:0] lcl_logid;
  logic          out_valid;
  logic [N-1:0]  out_mask;
  logic          out_err;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  irq_dest_resolver #(.N(N), .CNT_W(8)) i_irq_dest_resolver (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_dest(req_dest), .req_logical(req_logical), .req_mode(req_mode),
    .lcl_logid(lcl_logid), .out_valid(out_valid), .out_mask(out_mask),
    .out_err(out_err)
  );

  task automatic check(string tag, logic ev, logic [N-1:0] em, logic ee);
    checks++;
    if (out_valid !== ev || out_mask !== em || out_err !== ee) begin
      errors++;
      $display("FAIL %s: valid/mask/err = %b/%h/%b expected %b/%h/%b",
               tag, out_valid, out_mask, out_err, ev, em, ee);
    end
  endtask

  task automatic send(logic [7:0] d, logic lg, logic [2:0] m);
    req_valid   = 1'b1;
    req_dest    = d;
    req_logical = lg;
    req_mode    = m;
    @(negedge clk);
    req_valid   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    req_dest = '0; req_logical = 1'b0; req_mode = '0; lcl_logid = IDS;
    do_reset();
    check("R1 reset state", 1'b0, 8'h00, 1'b0);

    for (int v = 0; v < 16; v++) begin
      send(VEC[v][20:13], VEC[v][12], VEC[v][11:9]);
      check($sformatf("table row %0d", v), 1'b1, VEC[v][8:1], VEC[v][0]);
    end

    // R9: idle cycle holds mask and error, drops valid
    @(negedge clk);
    check("R9 hold while idle", 1'b0, 8'h20, 1'b0);
    checks++;
    if (req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9 ready: %b expected 1", req_ready);
    end

    // R1: counter back at zero after reset
    do_reset();
    send(8'h03, 1'b1, 3'd1);
    check("R1 first pick after reset", 1'b1, 8'h01, 1'b0);

    // R6: wrap of the 8-bit counter with three matches (controllers 0,1,2)
    do_reset();
    lcl_logid = 64'h0000000000010101;
    for (int n = 0; n < 256; n++) begin
      send(8'h01, 1'b1, 3'd1);
      if (n == 1) check("R6 second pick", 1'b1, 8'h02, 1'b0);
      if (n == 255) check("R6 pick at 255", 1'b1, 8'h01, 1'b0);
    end
    send(8'h01, 1'b1, 3'd1);
    check("R6 pick after wrap", 1'b1, 8'h01, 1'b0);

    // R7: error then pass-through mode clears the error
    send(8'h00, 1'b0, 3'd1);
    check("R7 physical lowest priority", 1'b1, 8'h00, 1'b1);
    send(8'h00, 1'b0, 3'd2);
    check("R8 other mode after error", 1'b1, 8'h01, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule